// File: doc/BRIEF.md
# Configurable-Frame UART Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single output line. A producer offers a byte on a valid/ready handshake. The block takes it only while no frame is in flight. It then sends a start bit, the data bits least significant first, an optional parity bit and the stop period. All timing comes from a baud tick that pulses at sixteen times the bit rate, so one bit time is sixteen ticks.

An 8-bit line-control value sets the frame shape: data length, stop length, whether parity is sent, the parity sense, and stick parity. One bit of that value is a break request that pulls the line low at once. The block copies the shaping fields and the byte when it accepts a character. A change to line control in mid-frame therefore affects only later frames. The break bit is the exception and acts immediately.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in flight and break is off, `txd` is 1, `busy` is 0 and `tx_ready` is 1.
- R2: An accepted frame starts with a 0 start bit of 16 ticks. Then data bits of 16 ticks each are sent least significant first. `lcr[1:0]` sets the count: 0 = 5, 1 = 6, 2 = 7, 3 = 8 bits.
- R3: The stop period drives 1. With `lcr[2]`=0 it lasts 16 ticks. With `lcr[2]`=1 it lasts 24 ticks for 5-bit data and 32 ticks for 6, 7 or 8 bits. `busy` falls on the tick that ends it.
- R4: With `lcr[3]`=1, one parity bit of 16 ticks sits between the last data bit and the stop period. With `lcr[3]`=0 there is no parity bit.
- R5: With parity on and `lcr[5]`=0, `lcr[4]`=0 makes the number of ones across the data and parity bits odd, and `lcr[4]`=1 makes it even.
- R6: With `lcr[3]`=1 and `lcr[5]`=1, the parity bit is the inverse of `lcr[4]`, whatever the data.
- R7: While `lcr[6]`=1, `txd` is 0 in the same cycle, whether a frame is in flight or not. The frame's timing carries on underneath the break.
- R8: The data byte and `lcr[5:0]` are captured at acceptance. Changing `lcr[5:0]` during a frame does not alter that frame.
- R9: A byte is accepted only on a clock where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from acceptance until the frame ends, so `tx_valid` during a frame starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| lcr | input | 8 | Line control: [1:0] length, [2] stop, [3] parity on, [4] even, [5] stick, [6] break, [7] unused |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Block can take a byte |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in flight |

## Verification
The assertions check the following on every cycle:
- Break always forces the line low.
- The idle line is high.
- Acceptance drops the line into a start bit at once.
- `busy` only rises after an offered byte.
- `busy` only falls on a baud tick.

The frame contents need the bench's sweep, which covers every shaping setting with several bytes. That sweep checks the data order and length, the parity value for the normal and stick cases, and the exact tick count of each stop variant. It also checks that a mid-frame change of line control leaves the frame intact and that a byte offered while busy is dropped.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [7:0] lcr,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       txd,
  output logic       busy
);
  localparam int CW = $clog2(2 * OVERSAMPLE);
  localparam logic [CW-1:0] ONE_LAST  = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
  localparam logic [CW-1:0] TWO_LAST  = CW'(2 * OVERSAMPLE - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt, stop_last;
  logic [7:0]    shreg;
  logic [2:0]    bit_idx, last_idx;
  logic          par_en, par_bit, frame_bit;

  wire        accept  = tx_valid && tx_ready;
  wire [7:0]  masked  = tx_data & (8'hFF >> (2'd3 - lcr[1:0]));
  wire        ones_od = ^masked;
  wire        par_new = lcr[5] ? ~lcr[4] : (lcr[4] ? ones_od : ~ones_od);
  wire        bit_end = baud_tick && (cnt == ONE_LAST);
  wire        stp_end = baud_tick && (cnt == stop_last);

  assign tx_ready = (st == S_IDLE);
  assign busy     = (st != S_IDLE);

  always_comb begin
    unique case (st)
      S_START: frame_bit = 1'b0;
      S_DATA:  frame_bit = shreg[0];
      S_PAR:   frame_bit = par_bit;
      default: frame_bit = 1'b1;
    endcase
  end

  assign txd = frame_bit & ~lcr[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      bit_idx   <= '0;
      last_idx  <= '0;
      par_en    <= 1'b0;
      par_bit   <= 1'b0;
      stop_last <= ONE_LAST;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          st        <= S_START;
          cnt       <= '0;
          shreg     <= masked;
          bit_idx   <= '0;
          last_idx  <= 3'd4 + {1'b0, lcr[1:0]};
          par_en    <= lcr[3];
          par_bit   <= par_new;
          stop_last <= !lcr[2] ? ONE_LAST :
                       (lcr[1:0] == 2'd0) ? HALF_LAST : TWO_LAST;
        end
        S_START: if (baud_tick) begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
          if (bit_end) st <= S_DATA;
        end
        S_DATA: if (baud_tick) begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
          if (bit_end) begin
            shreg   <= shreg >> 1;
            bit_idx <= bit_idx + 1'b1;
            if (bit_idx == last_idx) st <= par_en ? S_PAR : S_STOP;
          end
        end
        S_PAR: if (baud_tick) begin
          cnt <= bit_end ? '0 : cnt + 1'b1;
          if (bit_end) st <= S_STOP;
        end
        S_STOP: if (baud_tick) begin
          cnt <= stp_end ? '0 : cnt + 1'b1;
          if (stp_end) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module uart_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       baud_tick,
  input logic [7:0] lcr,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       busy
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !lcr[6]) |-> txd);  // R1
  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (busy && (lcr[6] || !txd)));  // R2
  AST_STOP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(baud_tick));  // R3
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    lcr[6] |-> !txd);  // R7
  AST_BUSY_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_valid));  // R9
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .lcr(lcr),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .busy(busy)
);

// File: tb/uart_frame_tx_bench.sv
module uart_frame_tx_bench;
  logic       clk = 0, rst_n = 0, baud_tick = 0, tx_valid = 0;
  logic [7:0] lcr = 8'h00, tx_data = 8'h00;
  logic       tx_ready, txd, busy;
  int total = 0, bad = 0;
  bit done = 0;

  uart_frame_tx u_uart_frame_tx (.*);

  always #10 clk = ~clk;

  always @(negedge clk) baud_tick <= ~baud_tick;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] cfg, input logic [7:0] d,
                      input int brk_at, input bit poke);
    int len, ones, nb, stop_t, tot, n;
    bit par, t;
    len = 5 + cfg[1:0];
    ones = 0;
    for (int i = 0; i < len; i++) ones += d[i];
    if (cfg[5]) par = ~cfg[4];
    else par = cfg[4] ? (ones % 2) : 1 - (ones % 2);
    nb = 1 + len + cfg[3];
    stop_t = !cfg[2] ? 16 : (len == 5 ? 24 : 32);
    tot = 16 * nb + stop_t;
    @(negedge clk);
    lcr = {2'b00, cfg[5:0]};
    tx_data = d;
    tx_valid = 1;
    @(posedge clk);
    @(negedge clk);
    tx_valid = 0;
    tx_data = ~d;
    lcr = {2'b00, ~cfg[5:0]};
    n = 0;
    while (busy && n < 400) begin
      @(posedge clk);
      t = baud_tick;
      @(negedge clk);
      if (tx_valid) begin
        tx_valid = 0;
        chk("R9 ready while busy", tx_ready, 0);
      end
      if (!t) continue;
      n++;
      if (brk_at >= 0 && n == brk_at) lcr[6] = 1;
      if (brk_at >= 0 && n == brk_at + 16) lcr[6] = 0;
      if (poke && n == 40) begin
        tx_valid = 1;
        tx_data = 8'h00;
      end
      if (n % 16 == 8) begin
        int b = n / 16;
        int e;
        string r;
        if (b == 0) begin e = 0; r = "R2 start"; end
        else if (b <= len) begin e = d[b-1]; r = "R2/R8 data"; end
        else if (b < nb) begin e = par; r = cfg[5] ? "R6 stick" : "R5 parity"; end
        else begin e = 1; r = "R3 stop"; end
        if (brk_at >= 0 && n > brk_at && n <= brk_at + 16) begin
          e = 0;
          r = "R7 break";
        end
        if (b <= nb) chk(r, txd, e);
      end
    end
    chk("R3/R4 frame ticks", n, tot);
    chk("R1 idle line", txd, 1);
    chk("R9 ready after frame", tx_ready, 1);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk("R9 offer while busy dropped", busy, 0);
    end
  endtask

  initial begin
    logic [7:0] dv [4] = '{8'h00, 8'hFF, 8'hA5, 8'h36};
    #1;
    chk("R1 reset txd", txd, 1);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset ready", tx_ready, 1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    lcr = 8'h40;
    #1;
    chk("R7 idle break", txd, 0);
    chk("R7 idle break busy", busy, 0);
    lcr = 8'h00;
    #1;
    chk("R1 break cleared", txd, 1);
    for (int c = 0; c < 64; c++)
      for (int k = 0; k < 4; k++)
        send(8'(c), dv[k], -1, 1'b0);
    send(8'h0B, 8'h5C, 20, 1'b0);
    send(8'h1C, 8'h13, 100, 1'b1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=0 exp=1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule